// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a watchdog peripheral that sits on an APB bus and guards a processor against software lockup. A down-counter runs from a programmable reload value toward zero. Software must service it periodically by writing a fixed key word to a dedicated service register, which restarts the count. If the count runs out first, the block takes the action selected in its control register. It either issues a one-cycle reset request to the system reset logic, or raises a sticky timeout interrupt and parks the counter at zero.

Two status inputs from the processor shape this behaviour. While the debug-halt input is high, the count is frozen, so a debugger can stop the core without tripping a reset. While the sleep input is high and wake-up reporting is enabled, an expiry also raises a separate wake-up interrupt that can bring the core back. Both interrupt flags live in one status register and are cleared by writing ones to their bits.

The register map uses word offsets: 0x00 control (bit 0 run, bit 1 action select with 1 meaning interrupt and 0 meaning reset, bit 2 wake-up enable), 0x04 reload value, 0x08 live count (read only), 0x0C service (write only, key 0x5EEDC0DE), 0x10 status (bit 0 timeout, bit 1 wake-up).

Top module: `guard_timer`

## Requirements
- R1: After reset the control register and status register read 0, the reload register and the live count both read the reset reload value 0x400, and rst_req_o, tmo_irq_o and wake_irq_o are low.
- R2: With control bit 0 set and the debug-halt input low, the live count decreases by exactly one per clock while it is above zero.
- R3: A write of 0x5EEDC0DE to offset 0x0C loads the live count from the reload register on the next clock edge; a write of any other value to 0x0C leaves the count unchanged.
- R4: A write to the reload register at 0x04 does not change the live count; the new value is used only at the next service or automatic reload.
- R5: With control bit 1 clear, the clock edge on which the count steps from 1 to 0 instead reloads the count from the reload register and drives rst_req_o high for exactly one cycle after that edge.
- R6: With control bit 1 set, the same expiry sets status bit 0, which drives tmo_irq_o; the live count then stays at zero, no further expiry occurs and no reset request is issued, until a service write.
- R7: While the debug-halt input is high the live count keeps its value and no expiry takes place.
- R8: An expiry while the sleep input is high and control bit 2 is set sets status bit 1, which drives wake_irq_o; an expiry with the sleep input low does not set it.
- R9: Writing 1 to a status bit at 0x10 clears it and lowers its interrupt output on the next edge; writing 0 leaves the bit unchanged; both status bits stay set until cleared.
- R10: Every access completes with zero wait states and no error response; reads of unmapped or unaligned offsets and of the service register return 0, and writes to the live-count register have no effect.
- R11: With control bit 0 clear the live count keeps its value and no expiry takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | AW (8) | APB byte address |
| pwdata_i | input | DW (32) | APB write data |
| prdata_o | output | DW (32) | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error, always low |
| dbg_halt_i | input | 1 | Processor debug-halt indication; freezes the count |
| cpu_sleep_i | input | 1 | Processor sleep indication; qualifies the wake-up interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |
| tmo_irq_o | output | 1 | Sticky timeout interrupt |
| wake_irq_o | output | 1 | Sticky wake-up interrupt |

## Verification
The properties assume the bus master follows the APB two-phase handshake, holding address, data and direction stable from setup into access, and that the debug-halt and sleep inputs are synchronous to the block clock. Service and status-clear writes are recognised in the checker only from the access phase, so a malformed transfer would break those assumptions. The bench drives every transfer as a clean setup phase followed by one access phase, changes the debug and sleep levels only between transfers on the falling clock edge, and uses word-aligned offsets except where an unaligned read is deliberately tested.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  // Word indices of the register map (byte offset divided by four)
  localparam int unsigned WIDX_CTRL  = 0;
  localparam int unsigned WIDX_LOAD  = 1;
  localparam int unsigned WIDX_COUNT = 2;
  localparam int unsigned WIDX_KICK  = 3;
  localparam int unsigned WIDX_STAT  = 4;

  // Status bit positions
  localparam int unsigned STAT_TMO  = 0;
  localparam int unsigned STAT_WAKE = 1;
  localparam int unsigned STAT_W    = 2;

  // Control register: bit0 run, bit1 interrupt action, bit2 wake enable
  typedef struct packed {
    logic wake_en;
    logic irq_mode;
    logic run;
  } gt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(gt_ctrl_t);

endpackage

// File: rtl/gt_rst_sync.sv
module gt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/gt_apb_regs.sv
module gt_apb_regs
  import guard_timer_pkg::*;
#(
  parameter int unsigned      AW       = 8,
  parameter int unsigned      DW       = 32,
  parameter logic [DW-1:0]    LOAD_RST = 'h400,
  parameter logic [DW-1:0]    KICK_KEY = 'h5EEDC0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [AW-1:0]     paddr_i,
  input  logic [DW-1:0]     pwdata_i,
  output logic [DW-1:0]     prdata_o,
  input  logic [DW-1:0]     count_i,
  input  logic [STAT_W-1:0] stat_i,
  output gt_ctrl_t          ctrl_o,
  output logic [DW-1:0]     load_o,
  output logic              kick_o,
  output logic [STAT_W-1:0] stat_clr_o
);

  localparam int unsigned WI = AW - 2;
  localparam logic [WI-1:0] A_CTRL  = WI'(WIDX_CTRL);
  localparam logic [WI-1:0] A_LOAD  = WI'(WIDX_LOAD);
  localparam logic [WI-1:0] A_COUNT = WI'(WIDX_COUNT);
  localparam logic [WI-1:0] A_KICK  = WI'(WIDX_KICK);
  localparam logic [WI-1:0] A_STAT  = WI'(WIDX_STAT);

  logic [WI-1:0] word;
  logic          aligned;
  logic          wr_acc;
  logic          rd_sel;

  gt_ctrl_t      ctrl_q, ctrl_d;
  logic          ctrl_en;
  logic [DW-1:0] load_q, load_d;
  logic          load_en;

  assign word    = paddr_i[AW-1:2];
  assign aligned = (paddr_i[1:0] == 2'b00);
  assign wr_acc  = psel_i & penable_i & pwrite_i & aligned;
  assign rd_sel  = psel_i & ~pwrite_i & aligned;

  // Write decode and next-state values
  always_comb begin
    ctrl_en    = wr_acc && (word == A_CTRL);
    load_en    = wr_acc && (word == A_LOAD);
    ctrl_d     = gt_ctrl_t'(pwdata_i[CTRL_W-1:0]);
    load_d     = pwdata_i;
    kick_o     = wr_acc && (word == A_KICK) && (pwdata_i == KICK_KEY);
    stat_clr_o = (wr_acc && (word == A_STAT)) ? pwdata_i[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= LOAD_RST;
    end else if (load_en) begin
      load_q <= load_d;
    end
  end

  // Read multiplexer; unmapped, unaligned and write-only locations give 0
  always_comb begin
    prdata_o = '0;
    if (rd_sel) begin
      case (word)
        A_CTRL:  prdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
        A_LOAD:  prdata_o = load_q;
        A_COUNT: prdata_o = count_i;
        A_STAT:  prdata_o = {{(DW-STAT_W){1'b0}}, stat_i};
        default: prdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;

endmodule

// File: rtl/gt_down_counter.sv
module gt_down_counter #(
  parameter int unsigned   DW      = 32,
  parameter logic [DW-1:0] RST_VAL = 'h400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic [DW-1:0] load_i,
  input  logic          tick_i,
  input  logic          wrap_i,
  output logic [DW-1:0] cnt_o,
  output logic          expire_o
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, cnt_d;

  // A service write wins over an expiry in the same cycle.
  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (reload_i) begin
      cnt_d = load_i;
    end else if (tick_i && (cnt_q != '0)) begin
      if (cnt_q == ONE) begin
        expire_o = 1'b1;
        cnt_d    = wrap_i ? load_i : '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_VAL;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/gt_status.sv
module gt_status
  import guard_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic              irq_mode_i,
  input  logic              wake_en_i,
  input  logic              sleep_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              rst_req_o
);

  logic [STAT_W-1:0] stat_q, stat_d, stat_set;
  logic              rreq_q, rreq_d;

  // Setting wins over a same-cycle clear so an event is never lost.
  always_comb begin
    stat_set            = '0;
    stat_set[STAT_TMO]  = expire_i & irq_mode_i;
    stat_set[STAT_WAKE] = expire_i & sleep_i & wake_en_i;
    stat_d              = (stat_q & ~clr_i) | stat_set;
    rreq_d              = expire_i & ~irq_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      rreq_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      rreq_q <= rreq_d;
    end
  end

  assign stat_o    = stat_q;
  assign rst_req_o = rreq_q;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int unsigned   AW       = 8,
  parameter int unsigned   DW       = 32,
  parameter int unsigned   SYNC_N   = 2,
  parameter logic [DW-1:0] LOAD_RST = 'h400,
  parameter logic [DW-1:0] KICK_KEY = 'h5EEDC0DE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  output logic          pready_o,
  output logic          pslverr_o,
  input  logic          dbg_halt_i,
  input  logic          cpu_sleep_i,
  output logic          rst_req_o,
  output logic          tmo_irq_o,
  output logic          wake_irq_o
);

  logic              rst_sync_n;
  gt_ctrl_t          ctrl;
  logic [DW-1:0]     load_val;
  logic [DW-1:0]     count;
  logic              kick;
  logic              tick;
  logic              expire;
  logic [STAT_W-1:0] stat;
  logic [STAT_W-1:0] stat_clr;

  gt_rst_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  gt_apb_regs #(
    .AW       (AW),
    .DW       (DW),
    .LOAD_RST (LOAD_RST),
    .KICK_KEY (KICK_KEY)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .pwdata_i   (pwdata_i),
    .prdata_o   (prdata_o),
    .count_i    (count),
    .stat_i     (stat),
    .ctrl_o     (ctrl),
    .load_o     (load_val),
    .kick_o     (kick),
    .stat_clr_o (stat_clr)
  );

  assign tick = ctrl.run & ~dbg_halt_i;

  gt_down_counter #(
    .DW      (DW),
    .RST_VAL (LOAD_RST)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .reload_i (kick),
    .load_i   (load_val),
    .tick_i   (tick),
    .wrap_i   (~ctrl.irq_mode),
    .cnt_o    (count),
    .expire_o (expire)
  );

  gt_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .expire_i   (expire),
    .irq_mode_i (ctrl.irq_mode),
    .wake_en_i  (ctrl.wake_en),
    .sleep_i    (cpu_sleep_i),
    .clr_i      (stat_clr),
    .stat_o     (stat),
    .rst_req_o  (rst_req_o)
  );

  assign tmo_irq_o  = stat[STAT_TMO];
  assign wake_irq_o = stat[STAT_WAKE];
  assign pready_o   = 1'b1;
  assign pslverr_o  = 1'b0;

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_timer_pkg::*;
#(
  parameter int unsigned   AW  = 8,
  parameter int unsigned   DW  = 32,
  parameter logic [DW-1:0] KEY = 'h5EEDC0DE
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          psel_i,
  input logic          penable_i,
  input logic          pwrite_i,
  input logic [AW-1:0] paddr_i,
  input logic [DW-1:0] pwdata_i,
  input logic          dbg_halt_i,
  input logic          run,
  input logic          irq_mode,
  input logic [DW-1:0] cnt,
  input logic          rst_req_o,
  input logic          tmo_irq_o,
  input logic          wake_irq_o
);

  localparam int unsigned WI = AW - 2;

  logic wr_acc, kick_wr, clr_tmo, clr_wake;

  assign wr_acc   = psel_i && penable_i && pwrite_i && (paddr_i[1:0] == 2'b00);
  assign kick_wr  = wr_acc && (paddr_i[AW-1:2] == WI'(WIDX_KICK)) && (pwdata_i == KEY);
  assign clr_tmo  = wr_acc && (paddr_i[AW-1:2] == WI'(WIDX_STAT)) && pwdata_i[STAT_TMO];
  assign clr_wake = wr_acc && (paddr_i[AW-1:2] == WI'(WIDX_STAT)) && pwdata_i[STAT_WAKE];

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run && !dbg_halt_i && !kick_wr && (cnt > DW'(1))) |=> (cnt == $past(cnt) - DW'(1)));

  a_r7_debug_freeze: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dbg_halt_i && !kick_wr) |=> ($stable(cnt) && !rst_req_o));

  a_r11_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run && !kick_wr) |=> ($stable(cnt) && !rst_req_o));

  a_r6_zero_park: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_mode && (cnt == '0) && !kick_wr) |=> ((cnt == '0) && !rst_req_o));

  a_r9_tmo_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tmo_irq_o && !clr_tmo) |=> tmo_irq_o);

  a_r9_wake_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wake_irq_o && !clr_wake) |=> wake_irq_o);

  a_r3_kick_loads: assert property (@(posedge clk_i) disable iff (!rst_n)
    kick_wr |=> (cnt != '0) || !rst_req_o);

endmodule

bind guard_timer guard_timer_chk #(
  .AW  (AW),
  .DW  (DW),
  .KEY (KICK_KEY)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .pwdata_i   (pwdata_i),
  .dbg_halt_i (dbg_halt_i),
  .run        (ctrl.run),
  .irq_mode   (ctrl.irq_mode),
  .cnt        (count),
  .rst_req_o  (rst_req_o),
  .tmo_irq_o  (tmo_irq_o),
  .wake_irq_o (wake_irq_o)
);

// File: tb/guard_timer_bench.sv
`timescale 1ns/1ps
module guard_timer_bench;

  localparam logic [7:0]  O_CTRL = 8'h00;
  localparam logic [7:0]  O_LOAD = 8'h04;
  localparam logic [7:0]  O_CNT  = 8'h08;
  localparam logic [7:0]  O_KICK = 8'h0C;
  localparam logic [7:0]  O_STAT = 8'h10;
  localparam logic [31:0] KEY    = 32'h5EEDC0DE;
  localparam logic [31:0] RSTLD  = 32'h0000_0400;
  localparam int          L      = 12;

  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr, dbg, slp, rreq, tirq, wirq;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  guard_timer u_guard_timer (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .dbg_halt_i(dbg),
    .cpu_sleep_i(slp), .rst_req_o(rreq), .tmo_irq_o(tirq), .wake_irq_o(wirq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: {req[3:0], write, addr[7:0], data[31:0], expected[31:0]}
  localparam int NV = 19;
  localparam logic [76:0] TBL [NV] = '{
    {4'd1,  1'b0, O_CTRL, 32'h0,  32'h0},       // R1 control after reset
    {4'd1,  1'b0, O_LOAD, 32'h0,  RSTLD},       // R1 reload after reset
    {4'd1,  1'b0, O_CNT,  32'h0,  RSTLD},       // R1 count after reset
    {4'd1,  1'b0, O_STAT, 32'h0,  32'h0},       // R1 status after reset
    {4'd10, 1'b1, O_CTRL, 32'h6,  32'h0},
    {4'd10, 1'b0, O_CTRL, 32'h0,  32'h6},       // R10 control readback
    {4'd4,  1'b1, O_LOAD, 32'h20, 32'h0},
    {4'd4,  1'b0, O_LOAD, 32'h0,  32'h20},      // R4 reload readback
    {4'd4,  1'b0, O_CNT,  32'h0,  RSTLD},       // R4 count untouched by reload write
    {4'd10, 1'b1, O_CNT,  32'h3,  32'h0},
    {4'd10, 1'b0, O_CNT,  32'h0,  RSTLD},       // R10 count is read only
    {4'd3,  1'b1, O_KICK, 32'h1234, 32'h0},
    {4'd3,  1'b0, O_CNT,  32'h0,  RSTLD},       // R3 wrong key ignored
    {4'd10, 1'b0, O_KICK, 32'h0,  32'h0},       // R10 service reads zero
    {4'd10, 1'b0, 8'h1C,  32'h0,  32'h0},       // R10 unmapped reads zero
    {4'd10, 1'b0, 8'h01,  32'h0,  32'h0},       // R10 unaligned reads zero
    {4'd3,  1'b1, O_KICK, KEY,    32'h0},
    {4'd3,  1'b0, O_CNT,  32'h0,  32'h20},      // R3 key reloads count
    {4'd10, 1'b1, O_CTRL, 32'h0,  32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    check("R10 pready", {31'b0, pready}, 32'h1);
    check("R10 pslverr", {31'b0, pslverr}, 32'h0);
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  // After a service write returns, the expiry edge is L cycles later.
  task automatic wait_low_then_high(input string tag, input int which);
    logic [2:0] o;
    repeat (L - 1) @(negedge clk);
    #1 o = {wirq, tirq, rreq};
    check({tag, " before expiry"}, {31'b0, o[which]}, 32'h0);
    @(negedge clk);
    #1 o = {wirq, tirq, rreq};
    check({tag, " at expiry"}, {31'b0, o[which]}, 32'h1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a, b, c;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; dbg = 1'b0; slp = 1'b0;
    repeat (4) @(negedge clk);
    #1 check("R1 outputs in reset", {29'b0, wirq, tirq, rreq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R1 outputs after reset", {29'b0, wirq, tirq, rreq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic        we;
      logic [7:0]  ad;
      logic [31:0] dt, ex, rd;
      {rq, we, ad, dt, ex} = TBL[i];
      if (we) apb_write(ad, dt);
      else begin
        apb_read(ad, rd);
        check($sformatf("R%0d table entry %0d", rq, i), rd, ex);
      end
    end

    // R5: reset action, single pulse, automatic reload
    apb_write(O_LOAD, L);
    apb_write(O_CTRL, 32'h1);
    apb_write(O_KICK, KEY);
    wait_low_then_high("R5 reset request", 0);
    @(negedge clk);
    #1 check("R5 pulse one cycle", {31'b0, rreq}, 32'h0);
    check("R5 no timeout irq", {31'b0, tirq}, 32'h0);
    apb_read(O_CNT, a);
    check("R5 count reloaded", {31'b0, (a > 32'd5 && a <= L)}, 32'h1);
    apb_write(O_CTRL, 32'h0);

    // R6: interrupt action, parking at zero
    apb_write(O_CTRL, 32'h3);
    apb_write(O_KICK, KEY);
    wait_low_then_high("R6 timeout irq", 1);
    check("R6 no reset request", {31'b0, rreq}, 32'h0);
    repeat (5) @(negedge clk);
    apb_read(O_CNT, a);
    check("R6 count parked", a, 32'h0);
    apb_read(O_STAT, a);
    check("R6 status bit0", a, 32'h1);
    apb_write(O_STAT, 32'h0);
    #1 check("R9 write 0 keeps bit", {31'b0, tirq}, 32'h1);
    apb_write(O_STAT, 32'h1);
    #1 check("R9 write 1 clears", {31'b0, tirq}, 32'h0);
    repeat (4) @(negedge clk);
    #1 check("R6 no refire at zero", {30'b0, tirq, rreq}, 32'h0);
    apb_write(O_KICK, KEY);
    apb_read(O_CNT, a);
    check("R3 service reload value", a, L - 2);
    apb_write(O_CTRL, 32'h0);

    // R7 debug freeze, R2 decrement rate, R11 stopped hold
    apb_write(O_LOAD, 32'd200);
    apb_write(O_CTRL, 32'h1);
    apb_write(O_KICK, KEY);
    dbg = 1'b1;
    apb_read(O_CNT, a);
    repeat (6) @(negedge clk);
    apb_read(O_CNT, b);
    check("R7 debug freezes count", b, a);
    dbg = 1'b0;
    apb_read(O_CNT, a);
    apb_read(O_CNT, b);
    check("R2 one step per cycle", a - b, 32'd3);
    apb_write(O_CTRL, 32'h0);
    apb_read(O_CNT, a);
    repeat (6) @(negedge clk);
    apb_read(O_CNT, c);
    check("R11 stopped count holds", c, a);

    // R8 wake-up during sleep
    apb_write(O_LOAD, L);
    slp = 1'b1;
    apb_write(O_CTRL, 32'h7);
    apb_write(O_KICK, KEY);
    wait_low_then_high("R8 wake irq", 2);
    check("R8 timeout irq too", {31'b0, tirq}, 32'h1);
    apb_read(O_STAT, a);
    check("R8 status both bits", a, 32'h3);
    apb_write(O_STAT, 32'h3);
    #1 check("R9 both cleared", {30'b0, wirq, tirq}, 32'h0);
    slp = 1'b0;
    apb_write(O_KICK, KEY);
    repeat (L) @(negedge clk);
    #1 check("R8 no wake when awake", {30'b0, wirq, tirq}, 32'h1);
    apb_write(O_CTRL, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule